// File: doc/BRIEF.md
# Vectored Priority Interrupt Controller

This block collects eight interrupt request lines from peripherals, picks the most urgent one, and raises a single interrupt toward the processor. When the processor acknowledges, the controller moves the winning line into service. It then returns an 8-bit vector made from a programmable 5-bit base and the 3-bit line number. Line 0 is the most urgent and line 7 the least. A line can preempt the service routine in progress only when it is strictly more urgent than every line already in service. An end-of-interrupt strobe retires the most urgent line in service.

A second, identical controller can be chained in. Its interrupt output drives request line 2 of the first controller, which gives fifteen usable lines. When line 2 wins an acknowledge, the first controller does not return a vector. Instead it pulses a cascade select so that the second controller answers. Configuration uses two write-only registers: the vector base and a per-line mask. Requests are captured on their rising edge. The vector return is a one-cycle valid pulse with no ready signal, because a processor acknowledge cycle cannot be stalled by the responder.

Top module: `irq_vec_ctrl`

## Requirements
- R1: After reset, int_o, vec_valid_o and casc_o are 0, every line is unmasked and the vector base is 0.
- R2: A rising edge on irq_i[i] latches line i as pending. If line i is unmasked and outranks everything in service, int_o is 1 from the clock edge that sampled the rising edge onward.
- R3: Line 0 has the highest priority and line 7 the lowest. An acknowledge selects the lowest-numbered pending, unmasked line.
- R4: On an accepted acknowledge (inta_i high while int_o is high), vec_valid_o is high for exactly the following cycle. In that cycle vec_o[7:3] is the base and vec_o[2:0] is the selected line.
- R5: An acknowledge clears the selected line from pending and marks it in service. A new request on the same line then does not raise int_o until that level is retired.
- R6: A pending line preempts service only if its number is lower than the lowest-numbered line in service. Equal or higher numbers wait.
- R7: A one-cycle eoi_i pulse removes the lowest-numbered line from the in-service set. Waiting requests that now outrank the in-service set raise int_o on the next cycle.
- R8: A set bit i in the mask register keeps pending line i from raising int_o or being selected. The pending state is kept and takes effect once the bit is cleared.
- R9: When line 2 is the acknowledged line and cascading is enabled, casc_o is high for one cycle and vec_valid_o stays 0. Line 2 still enters service.
- R10: inta_i while int_o is 0 produces no vec_valid_o or casc_o pulse and changes no state.
- R11: A write with cfg_addr_i = 0 loads the base from cfg_data_i[4:0]. A write with cfg_addr_i = 1 loads the mask from cfg_data_i[7:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_i | input | 8 | Request lines, captured on rising edge |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 1 | 0 = vector base, 1 = mask |
| cfg_data_i | input | 8 | Configuration write data |
| inta_i | input | 1 | Acknowledge pulse from the processor |
| eoi_i | input | 1 | End-of-interrupt pulse |
| int_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 8 | Returned vector |
| vec_valid_o | output | 1 | vec_o is valid this cycle |
| casc_o | output | 1 | Chained controller must supply the vector |

## Verification
Damage to the pending or in-service state shows up at the next acknowledge. The returned line number either skips the most urgent request or names a line that was already retired. A corrupt in-service bit shows within one cycle as int_o staying low while a more urgent line waits, or going high for a line of equal rank. An end-of-interrupt that clears the wrong bit is exposed by the order of the vectors that follow, so the bench checks the whole sequence of returned vectors against a queue of expectations.

// File: rtl/irq_pkg.sv
package irq_pkg;
  typedef enum logic {
    CFG_BASE = 1'b0,
    CFG_MASK = 1'b1
  } cfg_sel_e;
endpackage

// File: rtl/irq_req_latch.sv
module irq_req_latch #(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] req_i,
  input  logic [NLINES-1:0] clr_i,
  output logic [NLINES-1:0] pend_o
);
  logic [NLINES-1:0] req_q;
  logic [NLINES-1:0] rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      req_q  <= '0;
      pend_o <= '0;
    end else begin
      req_q  <= req_i;
      // a fresh edge wins over a same-cycle clear
      pend_o <= (pend_o & ~clr_i) | rise;
    end
  end
endmodule

// File: rtl/irq_prio_resolve.sv
module irq_prio_resolve #(
  parameter int NLINES = 8,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic [NLINES-1:0] vec_i,
  output logic              any_o,
  output logic [IDX_W-1:0]  idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = NLINES - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |vec_i;
endmodule

// File: rtl/irq_inservice.sv
module irq_inservice #(
  parameter int NLINES = 8,
  localparam int IDX_W = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] set_i,
  input  logic              eoi_i,
  output logic [NLINES-1:0] isr_o,
  output logic              busy_o,
  output logic [IDX_W-1:0]  top_o
);
  logic [NLINES-1:0] retire;

  irq_prio_resolve #(.NLINES(NLINES)) u_top (
    .vec_i (isr_o),
    .any_o (busy_o),
    .idx_o (top_o)
  );

  assign retire = (eoi_i && busy_o) ? (NLINES'(1) << top_o) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) isr_o <= '0;
    else        isr_o <= (isr_o & ~retire) | set_i;
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl #(
  parameter int NLINES    = 8,
  parameter int BASE_W    = 5,
  parameter bit CASC_EN   = 1'b1,
  parameter int CASC_LINE = 2,
  localparam int IDX_W = $clog2(NLINES),
  localparam int VEC_W = BASE_W + IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] irq_i,
  input  logic              cfg_we_i,
  input  logic              cfg_addr_i,
  input  logic [NLINES-1:0] cfg_data_i,
  input  logic              inta_i,
  input  logic              eoi_i,
  output logic              int_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              vec_valid_o,
  output logic              casc_o
);
  import irq_pkg::*;

  logic [BASE_W-1:0] base_q;
  logic [NLINES-1:0] mask_q;
  logic [NLINES-1:0] pend;
  logic [NLINES-1:0] cand;
  logic              cand_any;
  logic [IDX_W-1:0]  cand_idx;
  logic [NLINES-1:0] isr_q;
  logic              isr_busy;
  logic [IDX_W-1:0]  isr_top;
  logic              ack_go;
  logic [NLINES-1:0] ack_set;
  logic              ack_casc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      mask_q <= '0;
    end else if (cfg_we_i) begin
      if (cfg_sel_e'(cfg_addr_i) == CFG_BASE) base_q <= cfg_data_i[BASE_W-1:0];
      else                                    mask_q <= cfg_data_i;
    end
  end

  irq_req_latch #(.NLINES(NLINES)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .req_i  (irq_i),
    .clr_i  (ack_set),
    .pend_o (pend)
  );

  assign cand = pend & ~mask_q;

  irq_prio_resolve #(.NLINES(NLINES)) u_win (
    .vec_i (cand),
    .any_o (cand_any),
    .idx_o (cand_idx)
  );

  irq_inservice #(.NLINES(NLINES)) u_isr (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (ack_set),
    .eoi_i  (eoi_i),
    .isr_o  (isr_q),
    .busy_o (isr_busy),
    .top_o  (isr_top)
  );

  assign int_o    = cand_any && (!isr_busy || (cand_idx < isr_top));
  assign ack_go   = inta_i && int_o;
  assign ack_set  = ack_go ? (NLINES'(1) << cand_idx) : '0;
  assign ack_casc = CASC_EN && (cand_idx == IDX_W'(CASC_LINE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec_o       <= '0;
      vec_valid_o <= 1'b0;
      casc_o      <= 1'b0;
    end else begin
      vec_valid_o <= ack_go && !ack_casc;
      casc_o      <= ack_go && ack_casc;
      if (ack_go && !ack_casc) vec_o <= {base_q, cand_idx};
    end
  end
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk #(
  parameter int NLINES = 8,
  parameter int VEC_W  = 8,
  localparam int IDX_W = $clog2(NLINES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              inta_i,
  input logic              eoi_i,
  input logic              int_o,
  input logic [VEC_W-1:0]  vec_o,
  input logic              vec_valid_o,
  input logic              casc_o,
  input logic [NLINES-1:0] isr_q,
  input logic [NLINES-1:0] mask_q
);
  // R4: an accepted acknowledge answers on the next cycle
  a_r4_ack_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_i && int_o) |=> (vec_valid_o || casc_o));

  // R5: a returned vector names a line now in service
  a_r5_vec_in_service: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> isr_q[vec_o[IDX_W-1:0]]);

  // R7: end-of-interrupt retires exactly one level
  a_r7_eoi_retires_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_i && !(inta_i && int_o) && (isr_q != '0)) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));

  // R8: full mask silences the interrupt output
  a_r8_all_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !int_o);

  // R9: cascade select and own vector never coincide
  a_r9_casc_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(vec_valid_o && casc_o));

  // R10: acknowledge without a request yields nothing
  a_r10_spurious_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (inta_i && !int_o) |=> (!vec_valid_o && !casc_o));
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk #(.NLINES(NLINES), .VEC_W(VEC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .inta_i      (inta_i),
  .eoi_i       (eoi_i),
  .int_o       (int_o),
  .vec_o       (vec_o),
  .vec_valid_o (vec_valid_o),
  .casc_o      (casc_o),
  .isr_q       (isr_q),
  .mask_q      (mask_q)
);

// File: tb/test_irq_vec_ctrl.sv
module test_irq_vec_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq = '0;
  logic       cfg_we = 1'b0;
  logic       cfg_addr = 1'b0;
  logic [7:0] cfg_data = '0;
  logic       inta = 1'b0;
  logic       eoi = 1'b0;
  logic       int_o;
  logic [7:0] vec;
  logic       vec_valid;
  logic       casc;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [8:0] expq[$];   // bit 8 = cascade answer expected

  always #4 clk = ~clk;

  irq_vec_ctrl i_irq_vec_ctrl (
    .clk (clk), .rst_n (rst_n), .irq_i (irq),
    .cfg_we_i (cfg_we), .cfg_addr_i (cfg_addr), .cfg_data_i (cfg_data),
    .inta_i (inta), .eoi_i (eoi),
    .int_o (int_o), .vec_o (vec), .vec_valid_o (vec_valid), .casc_o (casc)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cfg(logic a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_irq(int line);
    irq[line] = 1'b1;
    @(negedge clk);
    irq[line] = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1;
    @(negedge clk);
    eoi = 1'b0;
  endtask

  task automatic ack(logic [8:0] exp);
    expq.push_back(exp);
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
  endtask

  // monitor: compares each answer against the queue
  always @(negedge clk) begin
    if (rst_n && (vec_valid || casc)) begin
      if (expq.size() == 0) begin
        checks++; errors++;
        $display("FAIL R10 actual %0h expected no answer", {casc, vec});
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        if (e[8]) check("R9", {31'd0, casc && !vec_valid}, 32'd1);
        else      check("R4", {23'd0, casc, vec}, {23'd0, e});
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 5000) begin @(posedge clk); cyc++; end
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual %0d expected done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 int", {31'd0, int_o}, 0);
    check("R1 valid", {31'd0, vec_valid}, 0);
    check("R1 casc", {31'd0, casc}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: base 0, all unmasked
    pulse_irq(6);
    check("R1 unmasked", {31'd0, int_o}, 1);
    ack({1'b0, 8'h06});
    do_eoi();

    // R11: base load
    cfg(1'b0, 8'h15);
    irq[5] = 1'b1; irq[3] = 1'b1;
    @(negedge clk);
    irq[5] = 1'b0; irq[3] = 1'b0;
    check("R2", {31'd0, int_o}, 1);
    ack({1'b0, 5'h15, 3'd3});                 // R3 lowest number wins
    check("R6 lower waits", {31'd0, int_o}, 0);
    pulse_irq(3);
    check("R5 same level waits", {31'd0, int_o}, 0);
    pulse_irq(1);
    check("R6 preempt", {31'd0, int_o}, 1);
    ack({1'b0, 5'h15, 3'd1});
    check("R6 nested quiet", {31'd0, int_o}, 0);
    do_eoi();
    check("R7 line3 still in service", {31'd0, int_o}, 0);
    do_eoi();
    check("R7 released", {31'd0, int_o}, 1);
    ack({1'b0, 5'h15, 3'd3});
    do_eoi();
    ack({1'b0, 5'h15, 3'd5});
    do_eoi();
    check("R7 empty", {31'd0, int_o}, 0);

    // R10: spurious acknowledge
    inta = 1'b1;
    @(negedge clk);
    inta = 1'b0;
    check("R10 no answer", {31'd0, vec_valid || casc}, 0);
    @(negedge clk);
    check("R10 int quiet", {31'd0, int_o}, 0);

    // R8: masking keeps pending
    cfg(1'b1, 8'h10);
    pulse_irq(4);
    check("R8 masked", {31'd0, int_o}, 0);
    cfg(1'b1, 8'h00);
    check("R8 unmasked", {31'd0, int_o}, 1);
    ack({1'b0, 5'h15, 3'd4});
    do_eoi();

    // R11: new base
    cfg(1'b0, 8'h0A);
    pulse_irq(7);
    ack({1'b0, 5'h0A, 3'd7});
    do_eoi();

    // R9: cascade line
    pulse_irq(2);
    ack({1'b1, 8'h00});
    pulse_irq(4);
    check("R9 line2 in service", {31'd0, int_o}, 0);
    do_eoi();
    check("R9 after eoi", {31'd0, int_o}, 1);
    ack({1'b0, 5'h0A, 3'd4});
    do_eoi();

    @(negedge clk);
    check("R4 queue drained", expq.size(), 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule